// File: doc/BRIEF.md
# Serial Peripheral Master with Register Port

This block is a serial peripheral interface master that a processor drives through six 32-bit registers on a simple synchronous write port with a combinational read path. Software first sets the character length, bit order, loopback and clock divider in the mode register while the enable bit is clear. It then sets enable and writes a word to the transmit register. Each accepted write shifts one character of 4 to 32 bits out on `mosi` and captures the same number of bits from `miso`. The received character can then be read from the receive register.

Data is right-justified in both directions: only the low bits of the transmit word are sent, and received bits fill the low bits of the receive word. A single holding register sits in front of the shift engine, so one character can wait while another is shifting. Two write-one-to-clear event bits report that the receiver holds a new word and that the transmit holding register is free. Each event bit has a mask bit, and the masked events drive the interrupt line.

Register word addresses: 0 mode, 1 event, 2 mask, 3 command (a plain read/write word with no effect), 4 transmit, 5 receive.

Top module: `spim_top`

## Requirements
- R1: After reset, mode, mask and receive read 0 and event reads 0x100. `irq`, `sck` and `mosi` are low.
- R2: Mode bits 23:20 hold the length code. Code 0 selects 32 bits, a code N from 3 to 15 selects N+1 bits, and codes 1 and 2 select 4 bits.
- R3: A mode write made while the stored enable bit (bit 24) is set leaves the length field unchanged. The other mode bits still update.
- R4: With divider P in mode bits 19:16, `sck` idles low and has a period of 4·(P+1) clocks. It rises 2·(P+1) clocks after the character starts. `miso` is sampled on each rising edge of `sck`, and `mosi` changes only on falling edges.
- R5: Mode bit 26 clear sends the character least significant bit first, starting at bit 0. Bit 26 set sends it most significant bit first, starting at bit L-1. Received bits go to the same positions, so the receive word holds the character in its low L bits with zeros above.
- R6: With mode bit 30 set, the serial output is fed back to the serial input, so the receive word equals the low L bits of the transmit word, and `mosi` stays 0.
- R7: A write to the transmit register while enable is clear is dropped. No `sck` activity follows, and no character starts when enable is set later.
- R8: Event bit 9 (receiver not empty) and the receive register update on the clock edge of the last falling `sck` edge, 1 + 4·L·(P+1) clocks after the transmit-write edge.
- R9: Writing 1 to event bit 9 or bit 8 clears that bit, and writing all ones clears both. Bit 8 (transmitter not full) is set again on every clock in which the holding register is empty.
- R10: A transmit write during a transfer is held and starts on the clock after the current character ends. While the word is held, bit 8 can be cleared and reads 0. A transmit write while the holding register is full is dropped.
- R11: `irq` equals (bit 9 AND mask bit 9) OR (bit 8 AND mask bit 8), using the mask register at address 2. A mask of zero keeps `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Masked event interrupt |

## Verification
A register write takes effect at the clock edge that captures it, so its result is read back at the next falling clock edge. A transmit write starts its character one edge later. From that point the bench uses a behavioural timer to predict `sck` at every falling clock edge: the level is high in the odd half-periods of length 2·(P+1). The receive-not-empty bit must still be 0 one clock before the 1 + 4·L·(P+1) deadline and must be 1 exactly at it. The bench acts as the slave: it presents each `miso` bit after the rising `sck` edge it detects, and it captures `mosi` at that same point, which lies between the edges where `mosi` may change.

// File: rtl/spim_pkg.sv
// spim_pkg: register word addresses and the bit positions of the control
// and event fields shared by the serial master and its checker.
// Assumes a 32-bit register word.
package spim_pkg;

    typedef enum logic [2:0] {
        RA_MODE  = 3'd0,
        RA_EVENT = 3'd1,
        RA_MASK  = 3'd2,
        RA_CMD   = 3'd3,
        RA_TX    = 3'd4,
        RA_RX    = 3'd5
    } spim_reg_e;

    localparam int REG_W    = 32;
    localparam int CODE_W   = 4;
    localparam int PRE_W    = 4;

    localparam int MB_LOOP  = 30;
    localparam int MB_REV   = 26;
    localparam int MB_MAST  = 25;
    localparam int MB_EN    = 24;
    localparam int MB_LEN   = 20;
    localparam int MB_PRE   = 16;

    localparam int EB_RNE   = 9;
    localparam int EB_TNF   = 8;

endpackage

// File: rtl/spim_baud.sv
// spim_baud: half-period timer for the serial clock. While run is high it
// pulses tick once every 2*(pre+1) clocks; while run is low it holds zero.
// Assumes pre is stable during a character.
module spim_baud #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    localparam int CW = PRE_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half_m1;

    // Last count of one half period: 2*(pre+1)-1.
    always_comb begin
        half_m1 = {pre, 1'b1};
        tick    = run && (cnt_q == half_m1);
    end

    // Count clocks inside the half period, restarting on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/spim_shift.sv
// spim_shift: shift engine for one character. It starts on start while idle,
// raises sck on a tick and samples sin there, then lowers sck on the next
// tick and moves to the next bit. done pulses in the cycle whose edge ends
// the character. Bit positions follow rev (LSB- or MSB-first) and len.
// Assumes len is 4..DW and is held constant while busy.
module spim_shift #(
    parameter int DW = 32,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic          tick,
    input  logic          rev,
    input  logic          sin,
    input  logic [DW-1:0] word,
    input  logic [LW-1:0] len,
    output logic          busy,
    output logic          sck,
    output logic          sout,
    output logic          done,
    output logic [DW-1:0] rx_word
);
    localparam int             IW  = $clog2(DW);
    localparam logic [LW-1:0]  ONE = LW'(1);

    logic [DW-1:0] tx_q;
    logic [DW-1:0] acc_q;
    logic [LW-1:0] idx_q;
    logic [IW-1:0] pos;
    logic          last;

    // Map the bit counter to a word position according to the bit order.
    always_comb begin
        pos     = rev ? IW'(len - ONE - idx_q) : idx_q[IW-1:0];
        last    = (idx_q == (len - ONE));
        done    = en && busy && tick && sck && last;
        sout    = busy ? tx_q[pos] : 1'b0;
        rx_word = acc_q;
    end

    // Character sequencing: load, rising-edge sample, falling-edge advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            sck   <= 1'b0;
            idx_q <= '0;
            tx_q  <= '0;
            acc_q <= '0;
        end else if (!en) begin
            busy <= 1'b0;
            sck  <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                sck   <= 1'b0;
                idx_q <= '0;
                tx_q  <= word;
                acc_q <= '0;
            end
        end else if (tick) begin
            if (!sck) begin
                sck        <= 1'b1;
                acc_q[pos] <= sin;
            end else begin
                sck <= 1'b0;
                if (last) begin
                    busy <= 1'b0;
                end else begin
                    idx_q <= idx_q + ONE;
                end
            end
        end
    end
endmodule

// File: rtl/spim_top.sv
// spim_top: register-programmed serial master. It holds the mode, event,
// mask, command, holding and receive registers, decodes the length code and
// routes loopback. One holding register feeds the shift engine.
// Assumes a single-cycle write strobe; reads are combinational.
module spim_top
    import spim_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic          irq
);
    localparam int LW = $clog2(DW) + 1;

    logic              loop_q, rev_q, mast_q, en_q;
    logic [CODE_W-1:0] len_q;
    logic [PRE_W-1:0]  pre_q;
    logic              mask_ne, mask_nf;
    logic [31:0]       cmd_q;
    logic [DW-1:0]     hold_q;
    logic              hold_full, hold_full_d;
    logic [DW-1:0]     rx_q;
    logic              ne_q, nf_q;
    logic [LW-1:0]     len_bits;
    logic              eng_busy, eng_sout, done, tick, start, sin;
    logic [DW-1:0]     eng_rx;
    logic              wr_mode, wr_event, wr_mask, wr_cmd, wr_tx, tx_take;

    // Decode write targets and the holding-register hand-off.
    always_comb begin
        wr_mode  = reg_wr && (reg_addr == RA_MODE);
        wr_event = reg_wr && (reg_addr == RA_EVENT);
        wr_mask  = reg_wr && (reg_addr == RA_MASK);
        wr_cmd   = reg_wr && (reg_addr == RA_CMD);
        wr_tx    = reg_wr && (reg_addr == RA_TX);
        tx_take  = wr_tx && en_q && !hold_full;
        start    = en_q && hold_full && !eng_busy;
        hold_full_d = hold_full;
        if (start)   hold_full_d = 1'b0;
        if (tx_take) hold_full_d = 1'b1;
    end

    // Length code to bit count: 0 -> DW, codes below 3 -> 4, N -> N+1.
    always_comb begin
        if (len_q == '0)
            len_bits = LW'(DW);
        else if (len_q < CODE_W'(3))
            len_bits = LW'(4);
        else
            len_bits = LW'(len_q) + LW'(1);
    end

    // Loopback routing of the serial path.
    always_comb begin
        sin  = loop_q ? eng_sout : miso;
        mosi = loop_q ? 1'b0 : eng_sout;
        irq  = (ne_q && mask_ne) || (nf_q && mask_nf);
    end

    // Mode, mask and command registers; length locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_q <= 1'b0; rev_q <= 1'b0; mast_q <= 1'b0; en_q <= 1'b0;
            len_q  <= '0;   pre_q <= '0;
            mask_ne <= 1'b0; mask_nf <= 1'b0;
            cmd_q  <= '0;
        end else begin
            if (wr_mode) begin
                loop_q <= reg_wdata[MB_LOOP];
                rev_q  <= reg_wdata[MB_REV];
                mast_q <= reg_wdata[MB_MAST];
                en_q   <= reg_wdata[MB_EN];
                pre_q  <= reg_wdata[MB_PRE +: PRE_W];
                if (!en_q) len_q <= reg_wdata[MB_LEN +: CODE_W];
            end
            if (wr_mask) begin
                mask_ne <= reg_wdata[EB_RNE];
                mask_nf <= reg_wdata[EB_TNF];
            end
            if (wr_cmd) cmd_q <= reg_wdata;
        end
    end

    // Holding register, receive register and the two event bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
            rx_q      <= '0;
            ne_q      <= 1'b0;
            nf_q      <= 1'b1;
        end else begin
            hold_full <= hold_full_d;
            if (tx_take) hold_q <= reg_wdata[DW-1:0];
            if (done)    rx_q   <= eng_rx;
            ne_q <= done || (ne_q && !(wr_event && reg_wdata[EB_RNE]));
            nf_q <= !hold_full_d || (nf_q && !(wr_event && reg_wdata[EB_TNF]));
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            RA_MODE:  reg_rdata = {1'b0, loop_q, 3'b000, rev_q, mast_q, en_q,
                                   len_q, pre_q, 16'h0000};
            RA_EVENT: reg_rdata = {22'h0, ne_q, nf_q, 8'h00};
            RA_MASK:  reg_rdata = {22'h0, mask_ne, mask_nf, 8'h00};
            RA_CMD:   reg_rdata = cmd_q;
            RA_RX:    reg_rdata = 32'(rx_q);
            default:  reg_rdata = '0;
        endcase
    end

    spim_baud #(.PRE_W(PRE_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_busy),
        .pre  (pre_q),
        .tick (tick)
    );

    spim_shift #(.DW(DW), .LW(LW)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_q),
        .start  (start),
        .tick   (tick),
        .rev    (rev_q),
        .sin    (sin),
        .word   (hold_q),
        .len    (len_bits),
        .busy   (eng_busy),
        .sck    (sck),
        .sout   (eng_sout),
        .done   (done),
        .rx_word(eng_rx)
    );
endmodule

// File: rtl/spim_chk.sv
// spim_chk: temporal checks on spim_top, attached by bind below.
// Assumes the synchronous active-low reset of the top module.
module spim_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_q,
    input logic [3:0] len_q,
    input logic       eng_busy,
    input logic       sck,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       hold_full,
    input logic       done,
    input logic       ne_q,
    input logic       mask_ne,
    input logic       mask_nf,
    input logic       irq
);
    // R3: length field only moves after a cycle with enable clear.
    a_r3_len_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> $stable(len_q));

    // R4: the serial clock is low whenever no character is shifting.
    a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !sck);

    // R7: a transmit write while disabled does not fill the holding register.
    a_r7_tx_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4 && !en_q) |=> $stable(hold_full));

    // R8: the end of a character raises receiver-not-empty.
    a_r8_done_sets_ne: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ne_q);

    // R11: with both mask bits clear the interrupt stays low.
    a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_ne && !mask_nf) |-> !irq);
endmodule

bind spim_top spim_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_q     (en_q),
    .len_q    (len_q),
    .eng_busy (eng_busy),
    .sck      (sck),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .hold_full(hold_full),
    .done     (done),
    .ne_q     (ne_q),
    .mask_ne  (mask_ne),
    .mask_nf  (mask_nf),
    .irq      (irq)
);

// File: tb/test_spim_top.sv
// test_spim_top: behavioural slave and timing model for spim_top.
module test_spim_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        sck, mosi, irq;
    logic        miso = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    spim_top i_spim_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck),
        .mosi(mosi), .miso(miso), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mk(bit lp, bit rv, bit en, int code, int pre);
        return (32'(lp) << 30) | (32'(rv) << 26) | (32'h1 << 25) | (32'(en) << 24)
             | (32'(code & 15) << 20) | (32'(pre & 15) << 16);
    endfunction

    task automatic setmode(bit lp, bit rv, int code, int pre);
        wr(3'd0, mk(lp, rv, 1'b0, code, pre));
        wr(3'd0, mk(lp, rv, 1'b1, code, pre));
    endtask

    function automatic int bitpos(int k, int len, bit rv);
        return rv ? (len - 1 - k) : k;
    endfunction

    // One character, compared against the timing model on every clock.
    task automatic xfer(input string tag, input logic [31:0] tx, input logic [31:0] slv,
                        input int len, input int pre, input bit rv, input bit lp);
        int h = 2 * (pre + 1);
        int total = 2 * len * h;
        int k = 0;
        logic prev = 1'b0;
        logic [31:0] m = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
        logic [31:0] d;
        wr(3'd1, 32'h200);
        miso = slv[bitpos(0, len, rv)];
        wr(3'd4, tx);
        for (int s = 0; s <= total; s++) begin
            @(negedge clk);
            check({tag, " R4 sck"}, 32'(sck), 32'(((s / h) % 2) == 1));
            if (sck && !prev) begin
                check({tag, " R5 mosi"}, 32'(mosi),
                      lp ? 32'h0 : 32'(tx[bitpos(k, len, rv)]));
                k++;
                if (k < len) miso = slv[bitpos(k, len, rv)];
            end
            prev = sck;
            if (s == total - 1) begin
                rd(3'd1, d);
                check({tag, " R8 ne early"}, d & 32'h200, 32'h0);
            end
        end
        rd(3'd1, d);
        check({tag, " R8 ne on time"}, d & 32'h200, 32'h200);
        rd(3'd5, d);
        check({tag, " R5/R6 rx"}, d, lp ? (tx & m) : (slv & m));
    endtask

    task automatic wait_ne(input string tag);
        logic [31:0] d = 32'h0;
        int n = 0;
        while (d[9] !== 1'b1 && n < 2000) begin
            @(negedge clk);
            rd(3'd1, d);
            n++;
        end
        check({tag, " ne seen"}, 32'(d[9]), 32'h1);
    endtask

    initial begin
        #600000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: values held in reset
        rd(3'd0, d); check("R1 mode", d, 32'h0);
        rd(3'd1, d); check("R1 event", d, 32'h100);
        rd(3'd2, d); check("R1 mask", d, 32'h0);
        rd(3'd5, d); check("R1 rx", d, 32'h0);
        check("R1 pins", {29'h0, irq, sck, mosi}, 32'h0);
        rst_n = 1'b1;

        // R7: transmit write while disabled is dropped
        wr(3'd4, 32'h55);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sck !== 1'b0) check("R7 sck quiet", 32'(sck), 32'h0);
        end
        setmode(1'b0, 1'b0, 7, 0);
        repeat (60) @(negedge clk);
        rd(3'd1, d); check("R7 no character", d & 32'h200, 32'h0);
        check("R7 sck low", 32'(sck), 32'h0);

        // R5 LSB first, 8 bits, divider 0
        xfer("lsb8", 32'h0000_03C5, 32'h0000_0096, 8, 0, 1'b0, 1'b0);
        // R5 MSB first
        setmode(1'b0, 1'b1, 7, 0);
        xfer("msb8", 32'h0000_01B3, 32'hFFFF_FF6D, 8, 0, 1'b1, 1'b0);
        // R2 code 0 = 32 bits, R4 divider 1 gives /8
        setmode(1'b0, 1'b1, 0, 1);
        xfer("w32", 32'hDEAD_BEEF, 32'h1357_9BDF, 32, 1, 1'b1, 1'b0);
        // R2 code 1 = 4 bits, divider 2
        setmode(1'b0, 1'b0, 1, 2);
        xfer("w4", 32'h0000_00FA, 32'h0000_0005, 4, 2, 1'b0, 1'b0);
        // R6 loopback, R2 code 15 = 16 bits
        setmode(1'b1, 1'b0, 15, 0);
        xfer("loop16", 32'h1234_ABCD, 32'h0000_FFFF, 16, 0, 1'b0, 1'b1);

        // R3: length write while enabled is ignored
        wr(3'd0, mk(1'b0, 1'b0, 1'b1, 7, 0));
        rd(3'd0, d);
        check("R3 len kept", (d >> 20) & 32'hF, 32'hF);
        check("R3 loop updated", (d >> 30) & 32'h1, 32'h0);
        xfer("R3 len16", 32'h0000_0F0F, 32'h0000_A55A, 16, 0, 1'b0, 1'b0);

        // R9: write-one-to-clear
        wr(3'd1, 32'h100);
        rd(3'd1, d); check("R9 nf re-set while empty", d, 32'h300);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d); check("R9 all ones", d, 32'h100);

        // R11: interrupt masking
        wr(3'd3, 32'hCAFE_0001);
        rd(3'd3, d); check("R11 command readback", d, 32'hCAFE_0001);
        xfer("R11 setup", 32'h0000_1111, 32'h0000_2222, 16, 0, 1'b0, 1'b0);
        check("R11 mask zero", 32'(irq), 32'h0);
        wr(3'd2, 32'h200);
        check("R11 ne irq", 32'(irq), 32'h1);
        wr(3'd1, 32'h200);
        check("R11 ne cleared", 32'(irq), 32'h0);
        wr(3'd2, 32'h100);
        check("R11 nf irq", 32'(irq), 32'h1);
        wr(3'd2, 32'h0);
        check("R11 mask off", 32'(irq), 32'h0);

        // R10: one-entry holding register
        setmode(1'b1, 1'b0, 7, 0);
        wr(3'd1, 32'h300);
        wr(3'd4, 32'h0000_00A1);
        repeat (5) @(negedge clk);
        wr(3'd4, 32'h0000_00B2);
        wr(3'd1, 32'h100);
        rd(3'd1, d); check("R10 nf clear while held", d & 32'h100, 32'h0);
        wr(3'd4, 32'h0000_00C3);
        wait_ne("R10 first");
        rd(3'd5, d); check("R10 first rx", d, 32'hA1);
        wr(3'd1, 32'h200);
        rd(3'd1, d); check("R10 nf after hand-off", d & 32'h100, 32'h100);
        wait_ne("R10 second");
        rd(3'd5, d); check("R10 second rx", d, 32'hB2);
        wr(3'd1, 32'h200);
        repeat (100) @(negedge clk);
        rd(3'd1, d); check("R10 third dropped", d & 32'h200, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule